// File: doc/BRIEF.md
# Banked Register Access Controller

This unit sits between a synchronous host port and the register space of a multi-channel line-interface device. The host has a 4-bit address, an 8-bit write bus, a registered read bus, an active-low chip select, and active-low read and write strobes. One address holds a bank-select code. That code decides which internal page every other address reaches: the line-interface page, one of eight frame-monitor pages, or one of eight data-link pages.

Two addresses have special behaviour. In a frame-monitor page, one address is a streaming status port. It walks through 21 status registers using an internal index. In a data-link page, one address pops the next byte from that link's receive FIFO. The line, framer and data-link functions are outside this block. They appear only as register arrays, a status store loaded from a side port, and small receive FIFOs filled from a push port.

A small state machine tracks the host window. Its states are S_IDLE (chip select high), S_OPEN (chip select low, no status read yet) and S_STREAM (a status stream is under way). Its transitions are:
- S_IDLE to S_OPEN when chip select falls.
- S_OPEN to S_STREAM on the first status-port read.
- S_OPEN or S_STREAM back to S_IDLE when chip select rises. This transition clears the status index.

Top module: `bank_reg_ctrl`

## Requirements
- R1: Address 0xD is the bank-select register in every page. A write stores the byte, a read returns the stored code, and the code changes only through such a write.
- R2: Bank code 0x00 selects the line-interface page. In this page every address other than 0xD reads and writes its own 8-bit register.
- R3: Bank codes 0x01 to 0x08 select frame-monitor pages 1 to 8. Each page has separate direct registers at every address except 0xD and 0xF.
- R4: Bank codes 0x11 to 0x18 select data-link pages 1 to 8. Each page has separate direct registers at every address except 0xD, 0x7 and 0xE.
- R5: Any other bank code selects no page. Reads of addresses other than 0xD return 0x00, and writes of addresses other than 0xD change no storage.
- R6: In a frame-monitor page, successive reads of 0xF within one chip-select window return status registers 0, 1, 2 and so on, in that order. Writes to 0xF are ignored.
- R7: After status register 20 has been returned, further reads of 0xF in the same window return status register 20 again. The index does not wrap.
- R8: Raising chip select ends the stream, so the first 0xF read of the next window returns status register 0.
- R9: In a data-link page, reads of 0x7 return that link's received bytes in arrival order, each byte once. A byte pushed into a full 4-entry FIFO is dropped.
- R10: A read of 0x7 on an empty FIFO returns 0x00, leaves the FIFO untouched, and sets a sticky underflow flag. The flag reads as bit 0 of address 0xE in that link's page (other bits 0). Any write to 0xE clears it.
- R11: A read or write acts exactly once, on the clock where its strobe is seen rising while chip select is low, however long the strobe was held low. A strobe edge with chip select high has no effect and leaves the read bus unchanged.
- R12: When a FIFO pop and a push to the same link fall in the same clock, the pop is decided on the FIFO contents before the push. The pushed byte is kept.
- R13: After reset the bank code is 0x00, all registers and status registers are 0x00, all FIFOs are empty, all underflow flags are clear, and the read bus is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the host strobes are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Active-low chip select |
| host_rd_n | input | 1 | Active-low read strobe; acts on its rising edge |
| host_wr_n | input | 1 | Active-low write strobe; acts on its rising edge |
| host_addr | input | 4 | Register address within the selected page |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, updated on the clock that completes a read |
| rx_push | input | 1 | Pushes rx_byte into the FIFO of link rx_link |
| rx_link | input | 3 | Target link of a push (0 = link 1) |
| rx_byte | input | 8 | Received byte to store |
| sr_load | input | 1 | Loads one status register |
| sr_mon | input | 3 | Target frame monitor of a load (0 = monitor 1) |
| sr_idx | input | 5 | Status register number 0..20; larger values are ignored |
| sr_val | input | 8 | Status value to store |

## Verification
A FIFO pop issued by the host and a receive push to the same link can land on the same clock edge. The bench provokes this in two ways. It raises the push strobe on exactly the clock where a read strobe of address 0x7 completes, once with an empty FIFO and once with bytes already queued. It also does this at random throughout the randomized run. The result is judged by a reference model that pops first and pushes second: the empty case must return 0x00 and flag underflow while the pushed byte still comes out on the following read.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [AW-1:0] A_BANK = 4'hD;
    localparam logic [AW-1:0] A_STAT = 4'hF;
    localparam logic [AW-1:0] A_POP  = 4'h7;
    localparam logic [AW-1:0] A_UFL  = 4'hE;

    typedef enum logic [1:0] {
        BK_LINE,
        BK_MON,
        BK_LINK,
        BK_NONE
    } bank_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OPEN,
        S_STREAM
    } host_st_e;

    // Map a bank-select code onto the kind of page it reaches.
    function automatic bank_kind_e decode_bank(input logic [DW-1:0] code, input int nch);
        if (code == '0) return BK_LINE;
        if (code[3:0] != 4'h0 && int'(code[3:0]) <= nch) begin
            if (code[7:4] == 4'h0) return BK_MON;
            if (code[7:4] == 4'h1) return BK_LINK;
        end
        return BK_NONE;
    endfunction

endpackage

// File: rtl/brc_host_fsm.sv
module brc_host_fsm
    import brc_pkg::*;
#(
    parameter int NSR = 21,
    localparam int IW = $clog2(NSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          stat_rd,
    output logic          rd_evt,
    output logic          wr_evt,
    output logic [IW-1:0] stat_idx
);

    localparam logic [IW-1:0] LAST = IW'(NSR - 1);

    host_st_e st, nxt;
    logic     rd_q, wr_q;

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (!cs_n) nxt = S_OPEN;
            S_OPEN:   if (cs_n) nxt = S_IDLE; else if (stat_rd) nxt = S_STREAM;
            S_STREAM: if (cs_n) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q     <= 1'b1;
            wr_q     <= 1'b1;
            stat_idx <= '0;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
            if (nxt == S_IDLE)
                stat_idx <= '0;
            else if (stat_rd && stat_idx != LAST)
                stat_idx <= stat_idx + 1'b1;
        end
    end

    always_comb begin
        rd_evt = !cs_n && !rd_q && rd_n;
        wr_evt = !cs_n && !wr_q && wr_n;
    end

    // R8
    idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (stat_idx == '0));

    // R7
    idx_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_idx <= LAST);

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cs_n && stat_idx == LAST) |=> (stat_idx == LAST));

    // R11
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !rd_evt);

endmodule

// File: rtl/brc_bank_regs.sv
module brc_bank_regs
    import brc_pkg::*;
#(
    parameter int NBANK = 17,
    localparam int BW = $clog2(NBANK),
    localparam int NREG = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] bank,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NBANK][NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
                for (int r = 0; r < NREG; r++)
                    mem[b][r] <= '0;
        end else if (we) begin
            mem[bank][addr] <= wdata;
        end
    end

    assign rdata = mem[bank][addr];

endmodule

// File: rtl/brc_status_store.sv
module brc_status_store
    import brc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int NSR = 21,
    localparam int CW = $clog2(NCH),
    localparam int IW = $clog2(NSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_mon,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_val,
    input  logic [CW-1:0] rd_mon,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_val
);

    logic [DW-1:0] sr [NCH][NSR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < NCH; m++)
                for (int i = 0; i < NSR; i++)
                    sr[m][i] <= '0;
        end else if (ld && int'(ld_idx) < NSR) begin
            sr[ld_mon][ld_idx] <= ld_val;
        end
    end

    assign rd_val = sr[rd_mon][rd_idx];

endmodule

// File: rtl/brc_rx_fifo.sv
module brc_rx_fifo
    import brc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int NW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_byte,
    input  logic          pop,
    input  logic          uf_clr,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          uflow
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [NW-1:0] cnt;
    logic          take, put;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty = (cnt == '0);
        take  = pop && !empty;
        put   = push && (cnt != NW'(DEPTH) || take);
        head  = mem[rptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wptr  <= '0;
            rptr  <= '0;
            cnt   <= '0;
            uflow <= 1'b0;
        end else begin
            if (put) begin
                mem[wptr] <= push_byte;
                wptr      <= step(wptr);
            end
            if (take) rptr <= step(rptr);
            unique case ({put, take})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (pop && empty) uflow <= 1'b1;
            else if (uf_clr)  uflow <= 1'b0;
        end
    end

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= NW'(DEPTH));

    // R10
    uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == '0) |=> uflow);

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == '0) |=> $stable(rptr));

    // R12
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && cnt != '0) |=> $stable(cnt));

endmodule

// File: rtl/bank_reg_ctrl.sv
module bank_reg_ctrl
    import brc_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int NSR        = 21,
    parameter int FIFO_DEPTH = 4,
    localparam int CW    = $clog2(NCH),
    localparam int IW    = $clog2(NSR),
    localparam int NBANK = 1 + 2 * NCH,
    localparam int BW    = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          rx_push,
    input  logic [CW-1:0] rx_link,
    input  logic [DW-1:0] rx_byte,
    input  logic          sr_load,
    input  logic [CW-1:0] sr_mon,
    input  logic [IW-1:0] sr_idx,
    input  logic [DW-1:0] sr_val
);

    logic [DW-1:0] bank_sel;
    bank_kind_e    kind;
    logic [CW-1:0] chan;
    logic          rd_evt, wr_evt, stat_rd;
    logic [IW-1:0] stat_idx;
    logic [BW-1:0] rf_bank;
    logic          rf_we;
    logic [DW-1:0] rf_rdata, sr_rdata, rd_val;

    logic [NCH-1:0] f_push, f_pop, f_clr, f_empty, f_uflow;
    logic [DW-1:0]  f_head [NCH];

    always_comb begin
        kind = decode_bank(bank_sel, NCH);
        chan = CW'(bank_sel[3:0] - 4'd1);
    end

    always_comb begin
        stat_rd = rd_evt && kind == BK_MON && host_addr == A_STAT;
        unique case (kind)
            BK_MON:  rf_bank = BW'(1) + BW'(chan);
            BK_LINK: rf_bank = BW'(1 + NCH) + BW'(chan);
            default: rf_bank = '0;
        endcase
        rf_we = 1'b0;
        if (wr_evt && host_addr != A_BANK) begin
            unique case (kind)
                BK_LINE: rf_we = 1'b1;
                BK_MON:  rf_we = (host_addr != A_STAT);
                BK_LINK: rf_we = (host_addr != A_POP) && (host_addr != A_UFL);
                default: rf_we = 1'b0;
            endcase
        end
    end

    brc_host_fsm #(.NSR(NSR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (host_cs_n),
        .rd_n     (host_rd_n),
        .wr_n     (host_wr_n),
        .stat_rd  (stat_rd),
        .rd_evt   (rd_evt),
        .wr_evt   (wr_evt),
        .stat_idx (stat_idx)
    );

    brc_bank_regs #(.NBANK(NBANK)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .bank  (rf_bank),
        .addr  (host_addr),
        .wdata (host_wdata),
        .rdata (rf_rdata)
    );

    brc_status_store #(.NCH(NCH), .NSR(NSR)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (sr_load),
        .ld_mon (sr_mon),
        .ld_idx (sr_idx),
        .ld_val (sr_val),
        .rd_mon (chan),
        .rd_idx (stat_idx),
        .rd_val (sr_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_link
        always_comb begin
            f_push[g] = rx_push && rx_link == CW'(g);
            f_pop[g]  = rd_evt && kind == BK_LINK && host_addr == A_POP && chan == CW'(g);
            f_clr[g]  = wr_evt && kind == BK_LINK && host_addr == A_UFL && chan == CW'(g);
        end
        brc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (f_push[g]),
            .push_byte (rx_byte),
            .pop       (f_pop[g]),
            .uf_clr    (f_clr[g]),
            .head      (f_head[g]),
            .empty     (f_empty[g]),
            .uflow     (f_uflow[g])
        );
    end

    always_comb begin
        rd_val = '0;
        unique case (kind)
            BK_LINE: rd_val = rf_rdata;
            BK_MON:  rd_val = (host_addr == A_STAT) ? sr_rdata : rf_rdata;
            BK_LINK: begin
                if (host_addr == A_POP)
                    rd_val = f_empty[chan] ? '0 : f_head[chan];
                else if (host_addr == A_UFL)
                    rd_val = {{(DW-1){1'b0}}, f_uflow[chan]};
                else
                    rd_val = rf_rdata;
            end
            default: rd_val = '0;
        endcase
        if (host_addr == A_BANK) rd_val = bank_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_sel   <= '0;
            host_rdata <= '0;
        end else begin
            if (wr_evt && host_addr == A_BANK) bank_sel <= host_wdata;
            if (rd_evt) host_rdata <= rd_val;
        end
    end

    // R1
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_evt && host_addr == A_BANK) |=> $stable(bank_sel));

    // R5
    dead_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && kind == BK_NONE && host_addr != A_BANK) |=> (host_rdata == '0));

endmodule

// File: tb/bank_reg_ctrl_test.sv
module bank_reg_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int NSR = 21;
    localparam int DEPTH = 4;

    logic       clk, rst_n;
    logic       host_cs_n, host_rd_n, host_wr_n;
    logic [3:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       rx_push;
    logic [2:0] rx_link;
    logic [7:0] rx_byte;
    logic       sr_load;
    logic [2:0] sr_mon;
    logic [4:0] sr_idx;
    logic [7:0] sr_val;

    bank_reg_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_push(rx_push), .rx_link(rx_link), .rx_byte(rx_byte),
        .sr_load(sr_load), .sr_mon(sr_mon), .sr_idx(sr_idx), .sr_val(sr_val)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model
    logic [7:0] m_regs [1+2*NCH][16];
    logic [7:0] m_sr   [NCH][NSR];
    logic [7:0] m_q    [NCH][DEPTH];
    int         m_n    [NCH];
    bit         m_uf   [NCH];
    logic [7:0] m_bs;
    int         m_cnt;
    int         total, bad;
    bit         done;

    function automatic int kind_of(input logic [7:0] c);
        if (c == 8'h00) return 0;
        if (c[3:0] >= 4'd1 && c[3:0] <= 4'd8) begin
            if (c[7:4] == 4'h0) return 1;
            if (c[7:4] == 4'h1) return 2;
        end
        return 3;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_read(input logic [3:0] a, output logic [7:0] v, output string tag);
        int k = kind_of(m_bs);
        int ch = int'(m_bs[3:0]) - 1;
        v = 8'h00; tag = "R5";
        if (a == 4'hD) begin v = m_bs; tag = "R1"; return; end
        case (k)
            0: begin v = m_regs[0][a]; tag = "R2"; end
            1: if (a == 4'hF) begin
                   v = m_sr[ch][m_cnt];
                   tag = (m_cnt == NSR-1) ? "R7" : "R6";
                   if (m_cnt < NSR-1) m_cnt++;
               end else begin v = m_regs[1+ch][a]; tag = "R3"; end
            2: if (a == 4'h7) begin
                   if (m_n[ch] == 0) begin v = 8'h00; m_uf[ch] = 1'b1; tag = "R10"; end
                   else begin
                       v = m_q[ch][0];
                       for (int i = 0; i < DEPTH-1; i++) m_q[ch][i] = m_q[ch][i+1];
                       m_n[ch]--; tag = "R9";
                   end
               end else if (a == 4'hE) begin v = {7'b0, m_uf[ch]}; tag = "R10"; end
               else begin v = m_regs[1+NCH+ch][a]; tag = "R4"; end
            default: begin v = 8'h00; tag = "R5"; end
        endcase
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        int k = kind_of(m_bs);
        int ch = int'(m_bs[3:0]) - 1;
        if (a == 4'hD) begin m_bs = d; return; end
        case (k)
            0: m_regs[0][a] = d;
            1: if (a != 4'hF) m_regs[1+ch][a] = d;
            2: if (a == 4'hE) m_uf[ch] = 1'b0;
               else if (a != 4'h7) m_regs[1+NCH+ch][a] = d;
            default: ;
        endcase
    endtask

    task automatic model_push(input int l, input logic [7:0] b);
        if (m_n[l] < DEPTH) begin m_q[l][m_n[l]] = b; m_n[l]++; end
    endtask

    task automatic cs_open();
        @(negedge clk) host_cs_n = 1'b0;
    endtask

    task automatic cs_close();
        @(negedge clk) host_cs_n = 1'b1;
        m_cnt = 0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk) begin host_addr = a; host_wdata = d; host_wr_n = 1'b0; end
        @(negedge clk) host_wr_n = 1'b1;
        @(negedge clk);
        model_write(a, d);
    endtask

    task automatic do_read(input logic [3:0] a, input int hold, input bit psh,
                           input int pl, input logic [7:0] pb, input string tag_ovr);
        logic [7:0] exp;
        string tag;
        @(negedge clk) begin host_addr = a; host_rd_n = 1'b0; end
        for (int i = 1; i < hold; i++) @(negedge clk);
        @(negedge clk) begin
            host_rd_n = 1'b1;
            if (psh) begin rx_push = 1'b1; rx_link = 3'(pl); rx_byte = pb; end
        end
        @(negedge clk) rx_push = 1'b0;
        model_read(a, exp, tag);
        if (psh) model_push(pl, pb);
        if (tag_ovr != "") tag = tag_ovr;
        check(host_rdata, exp, tag);
    endtask

    task automatic do_push(input int l, input logic [7:0] b);
        @(negedge clk) begin rx_push = 1'b1; rx_link = 3'(l); rx_byte = b; end
        @(negedge clk) rx_push = 1'b0;
        model_push(l, b);
    endtask

    task automatic do_sr(input int m, input int i, input logic [7:0] v);
        @(negedge clk) begin sr_load = 1'b1; sr_mon = 3'(m); sr_idx = 5'(i); sr_val = v; end
        @(negedge clk) sr_load = 1'b0;
        if (i < NSR) m_sr[m][i] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R11: watchdog expired, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] saved;
        int r, a;
        void'($urandom(32'd4242));
        total = 0; bad = 0; done = 0;
        for (int b = 0; b < 1+2*NCH; b++) for (int i = 0; i < 16; i++) m_regs[b][i] = 8'h00;
        for (int m = 0; m < NCH; m++) begin
            for (int i = 0; i < NSR; i++) m_sr[m][i] = 8'h00;
            m_n[m] = 0; m_uf[m] = 1'b0;
        end
        m_bs = 8'h00; m_cnt = 0;
        rst_n = 1'b0; host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_addr = '0; host_wdata = '0; rx_push = 0; rx_link = '0; rx_byte = '0;
        sr_load = 0; sr_mon = '0; sr_idx = '0; sr_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check(host_rdata, 8'h00, "R13");
        cs_open();
        do_read(4'hD, 1, 0, 0, 0, "R13");
        do_read(4'h3, 1, 0, 0, 0, "R13");

        // R2 / R3 page separation
        do_write(4'h5, 8'h29);
        do_read(4'h5, 1, 0, 0, 0, "R2");
        do_write(4'hD, 8'h03);
        do_read(4'h5, 1, 0, 0, 0, "R3");
        do_write(4'h5, 8'h77);
        do_read(4'h5, 2, 0, 0, 0, "R3");
        do_write(4'hD, 8'h00);
        do_read(4'h5, 1, 0, 0, 0, "R2");

        // R6 / R7 / R8 status stream
        for (int i = 0; i < NSR; i++) do_sr(4, i, 8'h40 + 8'(i));
        do_write(4'hD, 8'h05);
        do_write(4'hF, 8'hAA);
        for (int i = 0; i < NSR + 2; i++) do_read(4'hF, 1, 0, 0, 0, (i >= NSR-1) ? "R7" : "R6");
        cs_close(); cs_open();
        do_read(4'hF, 1, 0, 0, 0, "R8");
        do_read(4'hF, 1, 0, 0, 0, "R8");

        // R4 / R9 / R10 receive FIFO
        do_write(4'hD, 8'h18);
        do_write(4'h2, 8'h5C);
        do_read(4'h2, 1, 0, 0, 0, "R4");
        for (int i = 0; i < DEPTH + 1; i++) do_push(7, 8'hB0 + 8'(i));
        for (int i = 0; i < DEPTH; i++) do_read(4'h7, 1, 0, 0, 0, "R9");
        do_read(4'h7, 1, 0, 0, 0, "R10");
        do_read(4'hE, 1, 0, 0, 0, "R10");
        do_push(7, 8'hC1);
        do_read(4'h7, 3, 0, 0, 0, "R10");
        do_write(4'hE, 8'h00);
        do_read(4'hE, 1, 0, 0, 0, "R10");

        // R12 pop and push in one clock
        do_read(4'h7, 1, 1, 7, 8'hD1, "R12");
        do_read(4'hE, 1, 0, 0, 0, "R12");
        do_push(7, 8'hD2);
        do_read(4'h7, 1, 1, 7, 8'hD3, "R12");
        do_read(4'h7, 1, 0, 0, 0, "R12");
        do_read(4'h7, 1, 0, 0, 0, "R12");

        // R5 undefined bank
        do_write(4'hD, 8'h09);
        do_read(4'h5, 1, 0, 0, 0, "R5");
        do_write(4'h5, 8'hEE);
        do_read(4'hD, 1, 0, 0, 0, "R1");
        do_write(4'hD, 8'h00);
        do_read(4'h5, 1, 0, 0, 0, "R5");

        // R11 strobes with chip select high
        do_write(4'hD, 8'h12);
        do_push(1, 8'h91);
        do_write(4'h3, 8'h33);
        cs_close();
        saved = host_rdata;
        @(negedge clk) begin host_addr = 4'h7; host_rd_n = 1'b0; end
        @(negedge clk) host_rd_n = 1'b1;
        @(negedge clk) begin host_addr = 4'h3; host_wdata = 8'h44; host_wr_n = 1'b0; end
        @(negedge clk) host_wr_n = 1'b1;
        @(negedge clk);
        check(host_rdata, saved, "R11");
        cs_open();
        do_read(4'h3, 1, 0, 0, 0, "R11");
        do_read(4'h7, 1, 0, 0, 0, "R11");

        // randomized mix
        for (int n = 0; n < 1500; n++) begin
            r = $urandom_range(0, 9);
            case (r)
                0: begin
                    case ($urandom_range(0, 3))
                        0: do_write(4'hD, 8'h00);
                        1: do_write(4'hD, 8'h01 + 8'($urandom_range(0, 7)));
                        2: do_write(4'hD, 8'h11 + 8'($urandom_range(0, 7)));
                        default: case ($urandom_range(0, 3))
                            0: do_write(4'hD, 8'h09);
                            1: do_write(4'hD, 8'h10);
                            2: do_write(4'hD, 8'h19);
                            default: do_write(4'hD, 8'hFF);
                        endcase
                    endcase
                end
                1: begin
                    a = $urandom_range(0, 15);
                    if (a == 13) a = 14;
                    do_write(4'(a), 8'($urandom));
                end
                2, 3, 4: begin
                    case ($urandom_range(0, 2))
                        0: a = 15;
                        1: a = 7;
                        default: a = $urandom_range(0, 15);
                    endcase
                    do_read(4'(a), $urandom_range(1, 3), ($urandom_range(0, 3) == 0),
                            $urandom_range(0, 7), 8'($urandom), "");
                end
                5, 6: do_push($urandom_range(0, 7), 8'($urandom));
                7: begin cs_close(); cs_open(); end
                8: do_sr($urandom_range(0, 7), $urandom_range(0, 22), 8'($urandom));
                default: do_read(4'hE, 1, 0, 0, 0, "");
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule